// File: doc/BRIEF.md
# Cascadable Serial-In Parallel-Out Shift-Latch Receiver

The block receives a serial bit stream into a 20-stage shift register and holds a parallel copy of that register in a separate output latch. The serial clock and all control inputs are sampled on the system clock. A rising edge on the serial clock, seen while the unit is selected, moves every stage up by one and loads the serial data bit into stage 0. Whatever occupied the top stage is pushed out and lost, so a frame longer than 20 bits leaves only its last 20 bits in the register. The top stage is always visible on a cascade output. Several receivers can be chained by wiring one unit's cascade output to the next unit's serial input.

The parallel output changes only on a capture. Two capture policies are selectable. In strobe policy, a latch-enable input copies the register into the latch. In counted policy, the latch-enable input instead arms a bit counter, and the latch is loaded on the 20th shift that is counted. A controller that has to send whole bytes can therefore pad the front of a frame with don't-care bits. It pulses latch-enable afterwards, or it relies on the count.

Top module: `shift_latch_rx`

## Requirements
- R1: After reset the parallel output is all zeros and the cascade output is 0.
- R2: A serial-clock rising edge while select is high shifts the register by one, with the data bit entering stage 0. After exactly 20 shifts, the first bit sent sits in bit 19, the MSB of the parallel word.
- R3: Serial-clock edges while select is low do not shift. The cascade output and the register contents are unchanged, as a later capture shows.
- R4: The cascade output always shows stage 19. After each shift it equals the bit that was in stage 18 before that shift.
- R5: When more than 20 shifts occur, the earliest bits leave through stage 19 and are dropped. A capture yields the most recent 20 bits, with the latest bit in bit 0.
- R6: In strobe policy (mode input 0), the parallel output holds its value while latch-enable is low. On each system-clock edge where latch-enable is high, it loads the current register contents.
- R7: In counted policy (mode input 1), with select and latch-enable both high, shifts are counted. The parallel output is loaded with the register contents that result from the 20th counted shift. It holds its value at every other time.
- R8: In counted policy, a cycle with select low or latch-enable low clears the count, so the shifts counted before that cycle do not contribute to the next capture.
- R9: With two units chained (cascade output feeding the next serial input, all other inputs shared), the second unit receives the bits that overflow the first, in order.
- R10: In counted policy, the count restarts after each capture, so every further 20 counted shifts cause another capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock level; its rising edges shift the register |
| sdata_i | input | 1 | Serial data bit |
| sel_i | input | 1 | Select, active high; shifting and counting need it |
| latch_en_i | input | 1 | Strobe policy: capture command; counted policy: count enable |
| auto_mode_i | input | 1 | 0 = strobe policy, 1 = counted policy |
| par_o | output | WIDTH (20) | Parallel output latch |
| casc_o | output | 1 | Cascade output, top shift stage |

## Verification
The shift path is driven with random frames whose lengths run from exactly 20 bits to well past 20. Exact-length frames confirm bit placement. The longer frames show that only the newest bits survive and that the overflow appears on the cascade and in a chained second unit. In counted policy, a 19-then-1 split of the shifts separates an off-by-one counter from a correct one. Gaps in select or latch-enable placed mid-frame show whether a partial count is discarded. Edges sent while the unit is deselected, followed by a strobe, show that an unselected clock leaves the register untouched.

// File: rtl/srl_pkg.sv
package srl_pkg;

    typedef enum logic {
        CAP_STROBE  = 1'b0,
        CAP_COUNTED = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic lvl;
    } edge_state_t;

endpackage

// File: rtl/srl_edge_det.sv
module srl_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    import srl_pkg::*;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = sig_i;
        rise_o   = sig_i & ~st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srl_shift_reg.sv
module srl_shift_reg #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] sr_o,
    output logic [WIDTH-1:0] sr_next_o,
    output logic             msb_o
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] sr_d, sr_q, shifted;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_stage
            if (g == 0) begin : g_in
                assign shifted[g] = din_i;
            end else begin : g_mid
                assign shifted[g] = sr_q[g-1];
            end
        end
    endgenerate

    always_comb begin
        sr_d = sr_q;
        if (step_i) sr_d = shifted;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sr_o      = sr_q;
    assign sr_next_o = sr_d;
    assign msb_o     = sr_q[TOP];
endmodule

// File: rtl/srl_bit_counter.sv
module srl_bit_counter #(
    parameter int WIDTH = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic step_i,
    output logic full_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        full_o = 1'b0;
        if (!arm_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            if (st_q.cnt == LAST) begin
                full_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srl_latch_ctrl.sv
module srl_latch_ctrl #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             le_i,
    input  logic             full_i,
    input  logic [WIDTH-1:0] sr_i,
    input  logic [WIDTH-1:0] sr_next_i,
    output logic [WIDTH-1:0] par_o
);
    import srl_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } latch_state_t;

    latch_state_t st_d, st_q;
    cap_mode_e    mode;

    always_comb begin
        mode = cap_mode_e'(mode_i);
        st_d = st_q;
        unique case (mode)
            CAP_STROBE:  if (le_i)   st_d.word = sr_i;
            CAP_COUNTED: if (full_i) st_d.word = sr_next_i;
            default:     st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_o = st_q.word;
endmodule

// File: rtl/shift_latch_rx.sv
module shift_latch_rx #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             sel_i,
    input  logic             latch_en_i,
    input  logic             auto_mode_i,
    output logic [WIDTH-1:0] par_o,
    output logic             casc_o
);
    logic             rise_w;
    logic             step_w;
    logic             arm_w;
    logic             full_w;
    logic [WIDTH-1:0] shreg_w;
    logic [WIDTH-1:0] shreg_next_w;

    srl_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sclk_i),
        .rise_o (rise_w)
    );

    assign step_w = rise_w & sel_i;
    assign arm_w  = auto_mode_i & sel_i & latch_en_i;

    srl_shift_reg #(.WIDTH(WIDTH)) u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_w),
        .din_i     (sdata_i),
        .sr_o      (shreg_w),
        .sr_next_o (shreg_next_w),
        .msb_o     (casc_o)
    );

    srl_bit_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm_w),
        .step_i (step_w),
        .full_o (full_w)
    );

    srl_latch_ctrl #(.WIDTH(WIDTH)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (auto_mode_i),
        .le_i      (latch_en_i),
        .full_i    (full_w),
        .sr_i      (shreg_w),
        .sr_next_i (shreg_next_w),
        .par_o     (par_o)
    );
endmodule

// File: rtl/srl_rx_checker.sv
module srl_rx_checker #(
    parameter int WIDTH = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_i,
    input logic             sdata_i,
    input logic             sel_i,
    input logic             latch_en_i,
    input logic             auto_mode_i,
    input logic [WIDTH-1:0] par_o,
    input logic             casc_o,
    input logic             step_w,
    input logic [WIDTH-1:0] shreg_w
);
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && $rose(sclk_i) |=> shreg_w[0] == $past(sdata_i)); // R2

    AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> $stable(shreg_w) && $stable(casc_o)); // R3

    AST_CASC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        step_w |=> casc_o == $past(shreg_w[WIDTH-2])); // R4

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode_i && !latch_en_i |=> $stable(par_o)); // R6

    AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode_i && latch_en_i |=> par_o == $past(shreg_w)); // R6

    AST_COUNT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode_i && !step_w |=> $stable(par_o)); // R7

    AST_COUNT_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode_i && !(sel_i && latch_en_i) |=> $stable(par_o)); // R8
endmodule

bind shift_latch_rx srl_rx_checker #(.WIDTH(WIDTH)) u_rx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (sclk_i),
    .sdata_i     (sdata_i),
    .sel_i       (sel_i),
    .latch_en_i  (latch_en_i),
    .auto_mode_i (auto_mode_i),
    .par_o       (par_o),
    .casc_o      (casc_o),
    .step_w      (step_w),
    .shreg_w     (shreg_w)
);

// File: tb/test_shift_latch_rx.sv
`timescale 1ns/1ps
module test_shift_latch_rx;
    localparam int W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, sel = 1'b0, le = 1'b0, amode = 1'b0;
    logic [W-1:0] par_a, par_b;
    logic casc_a, casc_b;

    logic [W-1:0] m_a = '0, m_b = '0, e_par_a = '0, e_par_b = '0;
    int cnt_m = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_latch_rx #(.WIDTH(W)) i_shift_latch_rx (
        .clk(clk), .rst_n(rst_n), .sclk_i(sck), .sdata_i(sdi), .sel_i(sel),
        .latch_en_i(le), .auto_mode_i(amode), .par_o(par_a), .casc_o(casc_a));

    shift_latch_rx #(.WIDTH(W)) i_shift_latch_rx_b (
        .clk(clk), .rst_n(rst_n), .sclk_i(sck), .sdata_i(casc_a), .sel_i(sel),
        .latch_en_i(le), .auto_mode_i(amode), .par_o(par_b), .casc_o(casc_b));

    function automatic logic [W-1:0] push(input logic [W-1:0] r, input logic b);
        return {r[W-2:0], b};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sdi = b; sck = 1'b1;
        if (sel) begin
            m_b = push(m_b, m_a[W-1]);
            m_a = push(m_a, b);
            if (amode && le) begin
                cnt_m++;
                if (cnt_m == W) begin
                    cnt_m = 0; e_par_a = m_a; e_par_b = m_b;
                end
            end
        end
        @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic shift_rand(input int n);
        for (int i = 0; i < n; i++) shift_bit(1'($urandom));
    endtask

    task automatic strobe();
        @(negedge clk); le = 1'b1;
        @(negedge clk); le = 1'b0;
        e_par_a = m_a; e_par_b = m_b;
    endtask

    task automatic gap_sel();
        @(negedge clk); sel = 1'b0; cnt_m = 0;
        @(negedge clk); sel = 1'b1;
    endtask

    task automatic gap_le();
        @(negedge clk); le = 1'b0; cnt_m = 0;
        @(negedge clk); le = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset par", par_a, '0);
        chk("R1 reset casc", W'(casc_a), '0);

        // strobe policy, exact length then longer frames
        sel = 1'b1;
        shift_bit(1'b1);
        for (int i = 0; i < W - 1; i++) shift_bit(1'b0);
        chk("R6 hold before strobe", par_a, '0);
        chk("R4 casc shows first bit", W'(casc_a), W'(1));
        strobe();
        chk("R2 first bit lands in MSB", par_a, 20'h80000);

        for (int k = 0; k < 5; k++) begin
            held = par_a;
            shift_rand(W + 1 + int'($urandom % 25));
            chk("R6 hold while latch-enable low", par_a, held);
            chk("R4 casc is top stage", W'(casc_a), W'(m_a[W-1]));
            strobe();
            chk("R5 newest 20 bits captured", par_a, e_par_a);
            chk("R9 chained unit gets overflow", par_b, e_par_b);
        end

        // deselected clocks
        held = par_a;
        @(negedge clk); sel = 1'b0;
        shift_rand(9);
        chk("R3 casc unchanged when deselected", W'(casc_a), W'(m_a[W-1]));
        strobe();
        chk("R3 register unchanged when deselected", par_a, e_par_a);
        chk("R3 strobe value equals prior contents", par_a, held);

        // counted policy
        @(negedge clk); sel = 1'b1; amode = 1'b1; le = 1'b1; cnt_m = 0;
        shift_rand(W - 1);
        chk("R7 no capture at 19 shifts", par_a, held);
        shift_rand(1);
        chk("R7 capture at 20th shift", par_a, m_a);
        chk("R9 chained capture at 20th shift", par_b, m_b);
        held = par_a;
        shift_rand(W - 1);
        chk("R10 no capture at 19 after restart", par_a, held);
        shift_rand(1);
        chk("R10 second capture", par_a, m_a);

        held = par_a;
        shift_rand(10);
        gap_sel();
        shift_rand(10);
        chk("R8 select gap discards count", par_a, held);
        shift_rand(10);
        chk("R8 capture after select gap", par_a, e_par_a);

        held = par_a;
        shift_rand(7);
        gap_le();
        shift_rand(W - 1);
        chk("R8 latch-enable gap discards count", par_a, held);
        shift_rand(1);
        chk("R8 capture after latch-enable gap", par_a, m_a);

        for (int k = 0; k < 4; k++) begin
            shift_rand(W);
            chk("R7 random counted frame", par_a, e_par_a);
            chk("R9 random counted frame chained", par_b, e_par_b);
        end

        done = 1'b1;
        summary();
    end
endmodule